// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the software-facing register front end of an interrupt routing controller. A CPU sees only three word-sized locations on a small memory-mapped bus. The first is an index select register. The second is a 32-bit data window that reaches whichever internal register the select value names. The third is an end-of-interrupt (EOI) location. Behind the window sit an identification register, a read-only version word, an arbitration alias of the identification register, and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves.

The dispatch logic that actually delivers interrupts lives outside this block. It reads any redirection entry through a dedicated table port. It owns the two hardware status bits of each entry (delivery status and remote IRR), which it updates through a status port. Every accepted entry write raises a one-cycle service request, so the dispatcher rescans the table. On the variant that supports it, a 4-byte write to the EOI location is forwarded as an EOI vector pulse.

Top module: `irq_route_window`

## Requirements
- R1: Only bus address bits 7:0 are decoded, so an address with any upper bits aliases its low byte. Offset 0x00 is the select register, 0x10 is the data window and 0x40 is the EOI location. Reads of any other offset return 0.
- R2: After reset every redirection entry holds 0x0000_0000_0001_0000 (only the mask bit 16 set), the select register is 0 and the identification field is 0.
- R3: A write to offset 0x00 of any size stores bits 7:0 of the write data as the select value. A read of offset 0x00 of any size returns it zero-extended.
- R4: A window access whose size is not 4 bytes is ignored: it reads 0 and changes no state.
- R5: With select 0 or 2, a window read returns the 4-bit identification in bits 27:24 and zeros elsewhere. A window write with select 0 stores write-data bits 27:24. Window writes with select 1 or 2 are ignored.
- R6: With select 1, a window read returns VERSION in bits 7:0 and (NPINS − 1) in bits 23:16 (0x0017_0020 by default).
- R7: A select value s ≥ 0x10 addresses entry (s − 0x10) >> 1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. A select naming no entry (3 to 0x0F, or an index ≥ NPINS) reads 0 through the window and ignores writes.
- R8: An entry write replaces the addressed half, then keeps only the writable bits (7:0 vector, 10:8 mode, 11, 13, 15 trigger, 16 mask, 63:56 destination) and restores the prior delivery status (bit 12) and remote IRR (bit 14). All other bits read 0.
- R9: If an entry's trigger bit 15 is 0 (edge) after a window write, its remote IRR bit 14 is cleared.
- R10: `svc_req` is high for exactly the one cycle after each accepted entry write, and at no other time.
- R11: When VERSION is 0x20, a 4-byte write to offset 0x40 produces `eoi_valid` high for one cycle in the next cycle, with `eoi_vec` equal to write-data bits 7:0. Other sizes, and any write when VERSION is 0x11, produce no pulse.
- R12: A status-port update sets bits 12 and 14 of entry `st_idx` to `st_dlvs` and `st_rirr`, and `tbl_entry` always shows entry `tbl_idx` (0 if `tbl_idx` ≥ NPINS).
- R13: When a window write and a status update hit the same entry in one cycle, bits 12 and 14 come from the status port, and rule R9 is then applied on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (12) | Bus byte address, bits 7:0 decoded |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| tbl_idx | input | IDX_W (5) | Entry index for the dispatch read port |
| tbl_entry | output | 64 | Entry selected by `tbl_idx` |
| st_we | input | 1 | Status bit update strobe from dispatch logic |
| st_idx | input | IDX_W (5) | Entry index for the status update |
| st_dlvs | input | 1 | New delivery status value (bit 12) |
| st_rirr | input | 1 | New remote IRR value (bit 14) |
| svc_req | output | 1 | One-cycle pulse after an accepted entry write |
| eoi_valid | output | 1 | One-cycle pulse carrying an EOI vector |
| eoi_vec | output | 8 | EOI vector, held until the next EOI |

## Verification
The entry path is driven with all-ones writes, to show which bits are writable, and with level-mode and edge-mode patterns over entries whose status bits were first set by the dispatch port. These tell apart preservation of the read-only bits and the edge-triggered clearing of remote IRR. Collisions between a window write and a status update on the same entry separate the two priority rules. Select values just inside and outside the table and the register indices, together with sub-word sizes and aliased upper address bits, probe the decode. A second instance built with the older version value shows that the EOI path is absent there and that the version word changes.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam logic [7:0] OFS_SEL  = 8'h00;
  localparam logic [7:0] OFS_WIN  = 8'h10;
  localparam logic [7:0] OFS_EOI  = 8'h40;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] TBL_BASE = 8'h10;

  localparam int B_DLVS = 12;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;

  localparam logic [63:0] RW_BITS   = 64'hFF00_0000_0001_AFFF;
  localparam logic [63:0] RO_BITS   = 64'h0000_0000_0000_5000;
  localparam logic [63:0] RST_ENTRY = 64'h0000_0000_0001_0000;

  localparam logic [2:0] WORD_SIZE = 3'd4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SEL,
    ACC_WIN,
    ACC_EOI
  } acc_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_TBL
  } tgt_e;

endpackage

// File: rtl/irw_rst_sync.sv
module irw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic [7:0]       addr_lo,
  input  logic [7:0]       sel,
  output acc_e             acc,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);

  logic [7:0] off;
  logic [6:0] idx_full;

  always_comb begin
    unique case (addr_lo)
      OFS_SEL: acc = ACC_SEL;
      OFS_WIN: acc = ACC_WIN;
      OFS_EOI: acc = ACC_EOI;
      default: acc = ACC_NONE;
    endcase
  end

  assign off      = sel - TBL_BASE;
  assign idx_full = off[7:1];
  assign hi       = sel[0];
  assign idx      = IDX_W'(idx_full);

  always_comb begin
    if (sel == IDX_ID)       tgt = TGT_ID;
    else if (sel == IDX_VER) tgt = TGT_VER;
    else if (sel == IDX_ARB) tgt = TGT_ARB;
    else if ((sel >= TBL_BASE) && (int'(idx_full) < NPINS)) tgt = TGT_TBL;
    else                     tgt = TGT_NONE;
  end

endmodule

// File: rtl/irw_table.sv
module irw_table
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_hi,
  input  logic [31:0]           wr_data,
  input  logic                  st_we,
  input  logic [IDX_W-1:0]      st_idx,
  input  logic                  st_dlvs,
  input  logic                  st_rirr,
  output logic [NPINS-1:0][63:0] entries
);

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic        wr_hit, st_hit, ent_en;
    logic [63:0] merged, ent_nxt, ent_q;

    assign wr_hit = wr_en && (wr_idx == IDX_W'(g));
    assign st_hit = st_we && (st_idx == IDX_W'(g));
    assign ent_en = wr_hit || st_hit;

    always_comb begin
      merged  = wr_hi ? {wr_data, ent_q[31:0]} : {ent_q[63:32], wr_data};
      ent_nxt = ent_q;
      if (wr_hit) ent_nxt = (merged & RW_BITS) | (ent_q & RO_BITS);
      if (st_hit) begin
        ent_nxt[B_DLVS] = st_dlvs;
        ent_nxt[B_RIRR] = st_rirr;
      end
      if (wr_hit && !ent_nxt[B_TRIG]) ent_nxt[B_RIRR] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= RST_ENTRY;
      else if (ent_en) ent_q <= ent_nxt;
    end

    assign entries[g] = ent_q;
  end

endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
  import irw_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20,
  parameter int         ADDR_W  = 12,
  parameter int         IDX_W   = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  tbl_idx,
  output logic [63:0]       tbl_entry,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              st_dlvs,
  input  logic              st_rirr,
  output logic              svc_req,
  output logic              eoi_valid,
  output logic [7:0]        eoi_vec
);

  localparam logic        HAS_EOI  = (VERSION == 8'h20);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

  if (!((VERSION == 8'h11) || (VERSION == 8'h20))) begin : g_bad_version
    $error("irq_route_window: VERSION must be 8'h11 or 8'h20");
  end

  logic unused_addr_hi;
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

  logic rst_sync_n;

  irw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [7:0]       sel_q, sel_nxt;
  logic [3:0]       id_q, id_nxt;
  logic             sel_en, id_en;
  logic             svc_q, svc_nxt;
  logic             eoi_v_q, eoi_v_nxt;
  logic [7:0]       eoi_vec_q;
  acc_e             acc;
  tgt_e             tgt;
  logic [IDX_W-1:0] win_idx;
  logic             win_hi;
  logic             win_word, tbl_wr;
  logic [NPINS-1:0][63:0] tbl_q;
  logic [63:0]      win_entry;

  irw_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
    .addr_lo (bus_addr[7:0]),
    .sel     (sel_q),
    .acc     (acc),
    .tgt     (tgt),
    .idx     (win_idx),
    .hi      (win_hi)
  );

  assign win_word = (acc == ACC_WIN) && (bus_size == WORD_SIZE);
  assign tbl_wr   = bus_we && win_word && (tgt == TGT_TBL);

  irw_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tbl_wr),
    .wr_idx  (win_idx),
    .wr_hi   (win_hi),
    .wr_data (bus_wdata),
    .st_we   (st_we),
    .st_idx  (st_idx),
    .st_dlvs (st_dlvs),
    .st_rirr (st_rirr),
    .entries (tbl_q)
  );

  // next-state
  always_comb begin
    sel_en    = bus_we && (acc == ACC_SEL);
    sel_nxt   = bus_wdata[7:0];
    id_en     = bus_we && win_word && (tgt == TGT_ID);
    id_nxt    = bus_wdata[27:24];
    svc_nxt   = tbl_wr;
    eoi_v_nxt = HAS_EOI && bus_we && (acc == ACC_EOI) && (bus_size == WORD_SIZE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      svc_q     <= 1'b0;
      eoi_v_q   <= 1'b0;
      eoi_vec_q <= '0;
    end else begin
      if (sel_en)    sel_q     <= sel_nxt;
      if (id_en)     id_q      <= id_nxt;
      svc_q   <= svc_nxt;
      eoi_v_q <= eoi_v_nxt;
      if (eoi_v_nxt) eoi_vec_q <= bus_wdata[7:0];
    end
  end

  // read path
  assign win_entry = tbl_q[win_idx];

  always_comb begin
    bus_rdata = '0;
    unique case (acc)
      ACC_SEL: bus_rdata = {24'h0, sel_q};
      ACC_WIN: begin
        if (bus_size == WORD_SIZE) begin
          unique case (tgt)
            TGT_ID, TGT_ARB: bus_rdata = {4'h0, id_q, 24'h0};
            TGT_VER:         bus_rdata = VER_WORD;
            TGT_TBL:         bus_rdata = win_hi ? win_entry[63:32] : win_entry[31:0];
            default:         bus_rdata = '0;
          endcase
        end
      end
      default: bus_rdata = '0;
    endcase
  end

  assign tbl_entry = (int'(tbl_idx) < NPINS) ? tbl_q[tbl_idx] : '0;
  assign svc_req   = svc_q;
  assign eoi_valid = eoi_v_q;
  assign eoi_vec   = eoi_vec_q;

endmodule

// File: rtl/irw_chk.sv
module irw_chk
  import irw_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20,
  parameter int         IDX_W   = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             addr_lo,
  input logic                   bus_we,
  input logic [2:0]             bus_size,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [7:0]             sel_q,
  input logic [3:0]             id_q,
  input logic                   svc_req,
  input logic                   eoi_valid,
  input logic [7:0]             eoi_vec,
  input logic [NPINS-1:0][63:0] tbl_q
);

  logic       win_sz4, ent_write, last_wr_q;
  logic [6:0] ent_idx, last_idx_q;

  assign win_sz4   = (addr_lo == OFS_WIN) && (bus_size == WORD_SIZE);
  assign ent_idx   = 7'((sel_q - TBL_BASE) >> 1);
  assign ent_write = bus_we && win_sz4 && (sel_q >= TBL_BASE) && (int'(ent_idx) < NPINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr_q  <= 1'b0;
      last_idx_q <= '0;
    end else begin
      last_wr_q  <= ent_write;
      last_idx_q <= ent_idx;
    end
  end

  // R10
  svc_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_write |=> svc_req);

  // R10
  svc_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_write |=> !svc_req);

  // R4
  win_short_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_lo == OFS_WIN) && (bus_size != WORD_SIZE)) |-> (bus_rdata == 32'h0));

  // R4
  win_short_write_keeps_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (addr_lo == OFS_WIN) && (bus_size != WORD_SIZE)) |=> $stable(id_q));

  // R11
  eoi_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (addr_lo == OFS_EOI) && (bus_size == WORD_SIZE) && (VERSION == 8'h20))
      |=> (eoi_valid && (eoi_vec == $past(bus_wdata[7:0]))));

  // R11
  eoi_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (VERSION != 8'h20) |-> !eoi_valid);

  // R9
  edge_rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr_q |-> (tbl_q[last_idx_q][B_TRIG] || !tbl_q[last_idx_q][B_RIRR]));

endmodule

bind irq_route_window irw_chk #(.NPINS(NPINS), .VERSION(VERSION), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .addr_lo   (bus_addr[7:0]),
  .bus_we    (bus_we),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sel_q     (sel_q),
  .id_q      (id_q),
  .svc_req   (svc_req),
  .eoi_valid (eoi_valid),
  .eoi_vec   (eoi_vec),
  .tbl_q     (tbl_q)
);

// File: tb/irq_route_window_test.sv
module irq_route_window_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RWM = 64'hFF00_0000_0001_AFFF;
  localparam logic [63:0] ROM = 64'h0000_0000_0000_5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [4:0]  tbl_idx;
  logic        st_we, st_dlvs, st_rirr;
  logic [4:0]  st_idx;
  logic [31:0] rdata_a, rdata_b;
  logic [63:0] ent_a, ent_b;
  logic        svc_a, svc_b, eoi_a, eoi_b;
  logic [7:0]  vec_a, vec_b;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_route_window uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .tbl_idx(tbl_idx), .tbl_entry(ent_a), .st_we(st_we), .st_idx(st_idx),
    .st_dlvs(st_dlvs), .st_rirr(st_rirr), .svc_req(svc_a),
    .eoi_valid(eoi_a), .eoi_vec(vec_a)
  );

  irq_route_window #(.VERSION(8'h11)) uut_v11 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .tbl_idx(tbl_idx), .tbl_entry(ent_b), .st_we(st_we), .st_idx(st_idx),
    .st_dlvs(st_dlvs), .st_rirr(st_rirr), .svc_req(svc_b),
    .eoi_valid(eoi_b), .eoi_vec(vec_b)
  );

  // behavioural reference state
  logic [63:0] m_tbl [24];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic        m_svc, m_eoi;
  logic [7:0]  m_vec;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] mread(input logic [7:0] a8, input logic [2:0] sz,
                                        input logic [7:0] ver);
    int i;
    if (a8 == 8'h00) return {24'h0, m_sel};
    if (a8 != 8'h10 || sz != 3'd4) return 32'h0;
    if (m_sel == 8'd0 || m_sel == 8'd2) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'd1) return {8'h00, 8'd23, 8'h00, ver};
    if (m_sel < 8'h10) return 32'h0;
    i = (int'(m_sel) - 16) / 2;
    if (i >= 24) return 32'h0;
    return m_sel[0] ? m_tbl[i][63:32] : m_tbl[i][31:0];
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string rq, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [11:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, input logic swe, input logic [4:0] sidx,
                     input logic sdl, input logic sri, input string rq);
    logic [7:0]  a8;
    logic [63:0] e, mg, n;
    logic        tw;
    int          i;
    bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    st_we = swe; st_idx = sidx; st_dlvs = sdl; st_rirr = sri;
    #1;
    a8 = a[7:0];
    chk(64'(rdata_a), 64'(mread(a8, sz, 8'h20)), rq, "rdata");
    chk(64'(rdata_b), 64'(mread(a8, sz, 8'h11)), rq, "rdata v11");
    tw = 1'b0; i = 0; n = '0;
    if (we && a8 == 8'h00) m_sel = wd[7:0];
    else if (we && a8 == 8'h10 && sz == 3'd4) begin
      if (m_sel == 8'd0) m_id = wd[27:24];
      else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < 24) begin
        i  = (int'(m_sel) - 16) / 2;
        e  = m_tbl[i];
        mg = m_sel[0] ? {wd, e[31:0]} : {e[63:32], wd};
        n  = (mg & RWM) | (e & ROM);
        tw = 1'b1;
      end
    end
    if (tw) m_tbl[i] = n;
    if (swe && sidx < 5'd24) begin
      m_tbl[sidx][12] = sdl;
      m_tbl[sidx][14] = sri;
    end
    if (tw && !m_tbl[i][15]) m_tbl[i][14] = 1'b0;
    m_svc = tw;
    m_eoi = we && a8 == 8'h40 && sz == 3'd4;
    if (m_eoi) m_vec = wd[7:0];
    @(negedge clk);
    chk(64'(svc_a), 64'(m_svc), rq, "svc_req (R10)");
    chk(64'(svc_b), 64'(m_svc), rq, "svc_req v11 (R10)");
    chk(64'(eoi_a), 64'(m_eoi), rq, "eoi_valid (R11)");
    chk(64'(vec_a), 64'(m_vec), rq, "eoi_vec (R11)");
    chk(64'(eoi_b), 64'h0, rq, "eoi_valid v11 (R11)");
    chk(ent_a, (tbl_idx < 5'd24) ? m_tbl[tbl_idx] : 64'h0, rq, "tbl_entry (R12)");
    chk(ent_b, (tbl_idx < 5'd24) ? m_tbl[tbl_idx] : 64'h0, rq, "tbl_entry v11");
    bus_we = 1'b0; st_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] wd,
                    input string rq);
    cyc(1'b1, a, sz, wd, 1'b0, 5'd0, 1'b0, 1'b0, rq);
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] sz, input string rq);
    cyc(1'b0, a, sz, 32'h0, 1'b0, 5'd0, 1'b0, 1'b0, rq);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 24; k++) m_tbl[k] = 64'h0000_0000_0001_0000;
    m_sel = '0; m_id = '0; m_svc = 0; m_eoi = 0; m_vec = '0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 0; bus_size = 3'd4; bus_wdata = '0;
    tbl_idx = '0; st_we = 0; st_idx = '0; st_dlvs = 0; st_rirr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: reset contents through dispatch port and window
    for (int k = 0; k < 24; k += 7) begin
      tbl_idx = 5'(k);
      rd(12'h000, 3'd4, "R2");
    end
    wr(12'h000, 3'd4, 32'h0000_0010, "R2");
    rd(12'h010, 3'd4, "R2");
    wr(12'h000, 3'd4, 32'h0000_0000, "R2");
    rd(12'h010, 3'd4, "R2");

    // R3: select register with various sizes
    wr(12'h000, 3'd1, 32'hFFFF_FF5A, "R3");
    rd(12'h000, 3'd2, "R3");
    rd(12'h000, 3'd4, "R3");

    // R6: version word
    wr(12'h000, 3'd4, 32'h0000_0001, "R6");
    rd(12'h010, 3'd4, "R6");
    wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R5");
    rd(12'h010, 3'd4, "R6");

    // R5: identification and arbitration alias
    wr(12'h000, 3'd4, 32'h0000_0000, "R5");
    wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R5");
    rd(12'h010, 3'd4, "R5");
    wr(12'h000, 3'd4, 32'h0000_0002, "R5");
    rd(12'h010, 3'd4, "R5");
    wr(12'h010, 3'd4, 32'h0500_0000, "R5");
    rd(12'h010, 3'd4, "R5");

    // R4: short window accesses
    wr(12'h000, 3'd4, 32'h0000_0000, "R4");
    wr(12'h010, 3'd2, 32'h0300_0000, "R4");
    rd(12'h010, 3'd2, "R4");
    rd(12'h010, 3'd4, "R4");
    wr(12'h000, 3'd4, 32'h0000_001A, "R4");
    wr(12'h010, 3'd1, 32'h0000_0077, "R4");
    rd(12'h010, 3'd4, "R4");

    // R7/R8: all-ones to entry 5 both halves
    tbl_idx = 5'd5;
    wr(12'h000, 3'd4, 32'h0000_001A, "R7");
    wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R8");
    rd(12'h010, 3'd4, "R8");
    wr(12'h000, 3'd4, 32'h0000_001B, "R7");
    wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R8");
    rd(12'h010, 3'd4, "R8");

    // R12: status port sets both RO bits
    cyc(1'b0, 12'h000, 3'd4, 32'h0, 1'b1, 5'd5, 1'b1, 1'b1, "R12");
    cyc(1'b0, 12'h000, 3'd4, 32'h0, 1'b1, 5'd30, 1'b1, 1'b1, "R12");

    // R8: level write keeps RO bits
    wr(12'h000, 3'd4, 32'h0000_001A, "R8");
    wr(12'h010, 3'd4, 32'h0000_8031, "R8");
    rd(12'h010, 3'd4, "R8");

    // R9: edge write clears remote IRR but keeps delivery status
    wr(12'h010, 3'd4, 32'h0000_0031, "R9");
    rd(12'h010, 3'd4, "R9");
    // R9: high-half write leaves trigger edge -> clears
    cyc(1'b0, 12'h000, 3'd4, 32'h0, 1'b1, 5'd5, 1'b0, 1'b1, "R9");
    wr(12'h000, 3'd4, 32'h0000_001B, "R9");
    wr(12'h010, 3'd4, 32'h1200_0000, "R9");

    // R13: collision on the same entry
    tbl_idx = 5'd7;
    wr(12'h000, 3'd4, 32'h0000_001E, "R13");
    cyc(1'b1, 12'h010, 3'd4, 32'h0000_0044, 1'b1, 5'd7, 1'b0, 1'b1, "R13");
    cyc(1'b1, 12'h010, 3'd4, 32'h0001_8044, 1'b1, 5'd7, 1'b1, 1'b1, "R13");
    rd(12'h010, 3'd4, "R13");
    cyc(1'b1, 12'h010, 3'd4, 32'h0000_8055, 1'b1, 5'd9, 1'b1, 1'b1, "R13");

    // R7: boundaries of the table
    tbl_idx = 5'd23;
    wr(12'h000, 3'd4, 32'h0000_003F, "R7");
    wr(12'h010, 3'd4, 32'hA500_0000, "R7");
    rd(12'h010, 3'd4, "R7");
    wr(12'h000, 3'd4, 32'h0000_0040, "R7");
    wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R7");
    rd(12'h010, 3'd4, "R7");
    wr(12'h000, 3'd4, 32'h0000_0003, "R7");
    wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R7");
    rd(12'h010, 3'd4, "R7");
    wr(12'h000, 3'd4, 32'h0000_000F, "R7");
    rd(12'h010, 3'd4, "R7");
    tbl_idx = 5'd25;
    rd(12'h000, 3'd4, "R12");

    // several patterns across entries
    for (int k = 0; k < 24; k += 5) begin
      tbl_idx = 5'(k);
      wr(12'h000, 3'd4, 32'(16 + 2 * k), "R8");
      wr(12'h010, 3'd4, 32'h0001_0000 | 32'(k * 37), "R8");
      rd(12'h010, 3'd4, "R8");
    end

    // R1: aliasing of upper address bits and unmapped offsets
    wr(12'h300, 3'd4, 32'h0000_0001, "R1");
    rd(12'hF10, 3'd4, "R1");
    rd(12'h020, 3'd4, "R1");
    rd(12'h044, 3'd4, "R1");
    wr(12'h000, 3'd4, 32'h0000_0000, "R1");
    wr(12'h510, 3'd4, 32'h0900_0000, "R1");
    rd(12'h010, 3'd4, "R1");

    // R11: EOI forwarding
    wr(12'h040, 3'd4, 32'h1234_5677, "R11");
    rd(12'h040, 3'd4, "R11");
    wr(12'h040, 3'd2, 32'h0000_00AA, "R11");
    wr(12'hA40, 3'd4, 32'h0000_0091, "R11");
    wr(12'h040, 3'd1, 32'h0000_0033, "R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule